// File: doc/BRIEF.md
# Two-Stage Look-Ahead Processor Core

This block is a small multi-cycle processor that overlaps two pieces of work. While the current instruction is decoded and executed, the word after it is already being read from memory. Both halves run for one fixed three-cycle step and hand over together at the step boundary. One word-addressed memory inside the core serves both halves. Each half has its own address and data register pair, and the two halves use the memory port in different cycles of the step.

Two events break the overlap. First, a jump or a taken conditional branch makes the word fetched during that step useless, so the word is dropped and fetching resumes at the target. Second, a store can write the address that the fetch half has just read. The stale copy is then dropped and the same address is read again after the store has completed. Either event costs one empty step.

Memory is filled through a load port while reset is held. After the core halts, registers and memory words are read back through combinational peek ports. The core has four 16-bit registers. An instruction word carries the opcode in bits 15:12, the register number in bits 11:10 and a 10-bit address in bits 9:0. Only the low `AW` bits of an address select a memory word.

Top module: `lookahead_core`

## Requirements
- R1: While reset is held, `halted` is 0 and `retired` is 0. After reset is released, the registers hold 0 and the first step only fetches the word at address 0, so `retired` is still 0 after five clock edges and reaches 1 on the sixth.
- R2: Opcodes are 0 for no-operation, 1 for load, 2 for store, 3 for add, 4 for jump, 5 for branch-if-register-zero and F for halt. The opcode sits in bits 15:12, the register number in bits 11:10 and the address in bits 9:0.
- R3: Load copies the memory word at the address into the register. Add sets the register to the register plus the memory word, modulo 2^16. Store writes the register to the memory word at the address.
- R4: Every step lasts exactly three cycles. The PC and `retired` change only on the last edge of a step, and `retired` then rises by one for each valid instruction executed.
- R5: The fetch half reads memory only in the second cycle of a step. The execute half reads or writes memory only in the third cycle. The two never use the memory in the same cycle.
- R6: The number of clock edges from reset release until `halted` rises equals 3 × (1 + retired instructions + empty steps).
- R7: A jump, or a branch whose register is zero, discards the prefetched word and restarts fetching at the address field. This adds one empty step. A branch whose register is non-zero costs nothing extra.
- R8: A store whose memory index equals the index of the prefetched word invalidates that word and fetches it again after the store. The instruction that then executes is the newly stored value, and one empty step is added.
- R9: Halt counts as retired. `halted` then stays high, and the PC, the registers, memory and `retired` no longer change.
- R10: A no-operation retires and changes no register or memory word.
- R11: The load port writes memory only while reset is held. A write request while reset is released leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; also enables the load port |
| load_we | input | 1 | Memory write strobe for preloading |
| load_addr | input | AW | Memory index to preload |
| load_data | input | 16 | Word to preload |
| peek_addr | input | AW | Memory index to read back |
| peek_data | output | 16 | Combinational memory word at `peek_addr` |
| peek_reg | input | 2 | Register number to read back |
| peek_reg_val | output | 16 | Combinational value of the selected register |
| halted | output | 1 | High once a halt instruction has retired |
| retired | output | RW | Count of executed instructions |

## Verification
The assertions assume that reset is held low from time zero until memory has been filled. They also assume that the load port is only pulsed during reset, with one steady word per clock. The bench keeps to this for every program. It releases reset only at a falling edge after the last preload, and it drives the load port after halt only to show that the request is ignored. Each program is built so that it ends at a halt instruction within the watchdog window. Every program is compared against an instruction-by-instruction model kept in the bench. That model also counts the empty steps caused by redirects and by store hits.

// File: rtl/lookahead_core.sv
module lookahead_core #(
  parameter int AW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [15:0]   load_data,
  input  logic [AW-1:0] peek_addr,
  output logic [15:0]   peek_data,
  input  logic [1:0]    peek_reg,
  output logic [15:0]   peek_reg_val,
  output logic          halted,
  output logic [RW-1:0] retired
);

  localparam int DEPTH = 1 << AW;
  localparam int PW = 10;
  localparam logic [3:0] OP_NOP  = 4'h0;
  localparam logic [3:0] OP_LD   = 4'h1;
  localparam logic [3:0] OP_ST   = 4'h2;
  localparam logic [3:0] OP_ADD  = 4'h3;
  localparam logic [3:0] OP_JMP  = 4'h4;
  localparam logic [3:0] OP_BRZ  = 4'h5;
  localparam logic [3:0] OP_HALT = 4'hF;

  logic [15:0]   mem [DEPTH];
  logic [15:0]   rf [4];
  logic [1:0]    ph;
  logic [PW-1:0] pc, fa, ea;
  logic [15:0]   fd, ir, ed;
  logic          ir_v;

  logic [3:0]    op;
  logic [1:0]    rn;
  logic [PW-1:0] ad;
  logic          run, step_end, ex_go, f_rd, e_acc, st_we, taken, st_hit;
  logic [15:0]   f_rdata, e_rdata;

  assign op  = ir[15:12];
  assign rn  = ir[11:10];
  assign ad  = ir[9:0];
  assign run = !halted;

  assign step_end = run && (ph == 2'd2);
  assign f_rd     = run && (ph == 2'd1);
  assign ex_go    = step_end && ir_v;
  assign e_acc    = ex_go && (op == OP_LD || op == OP_ADD || op == OP_ST);
  assign st_we    = ex_go && (op == OP_ST);
  assign taken    = ex_go && (op == OP_JMP || (op == OP_BRZ && ed == 16'd0));
  assign st_hit   = st_we && (ea[AW-1:0] == fa[AW-1:0]);

  assign f_rdata      = mem[fa[AW-1:0]];
  assign e_rdata      = mem[ea[AW-1:0]];
  assign peek_data    = mem[peek_addr];
  assign peek_reg_val = rf[peek_reg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (load_we) mem[load_addr] <= load_data;
    end else if (st_we) begin
      mem[ea[AW-1:0]] <= ed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 2'd0;
      pc      <= '0;
      fa      <= '0;
      ea      <= '0;
      fd      <= '0;
      ed      <= '0;
      ir      <= '0;
      ir_v    <= 1'b0;
      halted  <= 1'b0;
      retired <= '0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else if (run) begin
      case (ph)
        2'd0: begin
          fa <= pc;
          if (ir_v) ea <= ad;
          ph <= 2'd1;
        end
        2'd1: begin
          fd <= f_rdata;
          ed <= rf[rn];
          ph <= 2'd2;
        end
        default: begin
          ph   <= 2'd0;
          ir   <= fd;
          ir_v <= !(taken || st_hit);
          if (taken)       pc <= ea;
          else if (st_hit) pc <= fa;
          else             pc <= fa + PW'(1);
          if (ir_v) begin
            retired <= retired + RW'(1);
            case (op)
              OP_LD:   rf[rn] <= e_rdata;
              OP_ADD:  rf[rn] <= rf[rn] + e_rdata;
              OP_HALT: halted <= 1'b1;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 2'd3);

  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_rd && e_acc));

  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 2'd2) |=> $stable(pc));

  a_r4_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 2'd2 || halted) |=> $stable(retired));

  a_r7_squash: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (!ir_v && pc == $past(ea)));

  a_r8_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit |=> (!ir_v && pc == $past(fa)));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(retired) && $stable(pc)));

  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_go && op == OP_NOP) |=> (rf[0] == $past(rf[0]) && rf[1] == $past(rf[1])
                                 && rf[2] == $past(rf[2]) && rf[3] == $past(rf[3])));

endmodule

// File: tb/lookahead_core_bench.sv
module lookahead_core_bench;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int RW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [15:0] HLT = 16'hF000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_we = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [15:0]   load_data = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [15:0]   peek_data;
  logic [1:0]    peek_reg = '0;
  logic [15:0]   peek_reg_val;
  logic          halted;
  logic [RW-1:0] retired;

  lookahead_core #(.AW(AW), .RW(RW)) u_lookahead_core (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .peek_reg(peek_reg), .peek_reg_val(peek_reg_val), .halted(halted),
    .retired(retired));

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int total_cyc = 0;

  logic [15:0] init_mem [DEPTH];
  logic [15:0] exp_mem [DEPTH];
  logic [15:0] exp_reg [4];
  int exp_ret, exp_bub;

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(logic [3:0] op, logic [1:0] r, logic [9:0] a);
    return {op, r, a};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) init_mem[i] = HLT;
  endtask

  task automatic model();
    logic [9:0] pc = '0;
    logic [15:0] w;
    logic [9:0] a;
    logic [1:0] r;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_mem[i];
    for (int i = 0; i < 4; i++) exp_reg[i] = '0;
    exp_ret = 0;
    exp_bub = 0;
    for (int k = 0; k < 5000; k++) begin
      w = exp_mem[pc[AW-1:0]];
      r = w[11:10];
      a = w[9:0];
      exp_ret++;
      if (w[15:12] == 4'hF) break;
      case (w[15:12])
        4'h1: exp_reg[r] = exp_mem[a[AW-1:0]];
        4'h3: exp_reg[r] = exp_reg[r] + exp_mem[a[AW-1:0]];
        4'h2: begin
          exp_mem[a[AW-1:0]] = exp_reg[r];
          if (a[AW-1:0] == AW'(pc + 10'd1)) exp_bub++;
        end
        default: ;
      endcase
      if (w[15:12] == 4'h4 || (w[15:12] == 4'h5 && exp_reg[r] == 16'd0)) begin
        exp_bub++;
        pc = a;
      end else begin
        pc = pc + 10'd1;
      end
    end
  endtask

  task automatic run_prog(string name);
    int cyc = 0;
    int bad = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 halted in reset", halted, 0);
    check("R1 retired in reset", retired, 0);
    for (int i = 0; i < DEPTH; i++) begin
      load_we = 1'b1;
      load_addr = AW'(i);
      load_data = init_mem[i];
      @(negedge clk);
    end
    load_we = 1'b0;
    model();
    rst_n = 1'b1;
    while (1) begin
      @(posedge clk);
      cyc++;
      total_cyc++;
      @(negedge clk);
      if (cyc == 5) check({"R1 no retire during first fetch ", name}, retired, 0);
      if (cyc == 6) check({"R4 first retire on sixth edge ", name}, retired, 1);
      if (halted) break;
      if (cyc > 20000) begin
        check({"R9 watchdog halt ", name}, 0, 1);
        break;
      end
    end
    check({"R6 cycles ", name}, cyc, 3 * (1 + exp_ret + exp_bub));
    check({"R9 retired ", name}, retired, exp_ret);
    for (int r = 0; r < 4; r++) begin
      peek_reg = 2'(r);
      #1;
      check({"R3 register ", name}, peek_reg_val, exp_reg[r]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      peek_addr = AW'(i);
      #1;
      if (peek_data !== exp_mem[i]) bad++;
    end
    check({"R3 memory mismatches ", name}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    check("R9 global watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] va [4];
    logic [15:0] wa [2];
    va[0] = 16'h0000; va[1] = 16'h0001; va[2] = 16'h7FFF; va[3] = 16'hFFFF;
    wa[0] = 16'h0001; wa[1] = 16'hFFFF;

    // R2 R3 R10: load, add, no-op, store over every register and edge values
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 4; v++)
        for (int w = 0; w < 2; w++) begin
          clear_prog();
          init_mem[0] = ins(4'h1, 2'(r), 10'd100);
          init_mem[1] = ins(4'h3, 2'(r), 10'd101);
          init_mem[2] = ins(4'h0, 2'(r), 10'd0);
          init_mem[3] = ins(4'h2, 2'(r), 10'd102);
          init_mem[100] = va[v];
          init_mem[101] = wa[w];
          init_mem[102] = 16'h1111;
          run_prog("alu sweep R3 R10");
        end

    // R7: countdown loop, branch taken only when counter reaches zero
    for (int n = 0; n < 7; n++) begin
      clear_prog();
      init_mem[0] = ins(4'h1, 2'd0, 10'd100);
      init_mem[1] = ins(4'h5, 2'd0, 10'd5);
      init_mem[2] = ins(4'h3, 2'd0, 10'd101);
      init_mem[3] = ins(4'h3, 2'd1, 10'd102);
      init_mem[4] = ins(4'h4, 2'd0, 10'd1);
      init_mem[5] = ins(4'h2, 2'd1, 10'd103);
      init_mem[100] = 16'(n);
      init_mem[101] = 16'hFFFF;
      init_mem[102] = 16'h0001;
      init_mem[103] = 16'h0000;
      run_prog("loop R7");
      check("R7 loop count", exp_mem[103], n);
    end

    // R8: store into the word after the store and at other distances
    for (int t = 1; t <= 4; t++) begin
      clear_prog();
      init_mem[0] = ins(4'h1, 2'd2, 10'd100);
      init_mem[1] = ins(4'h2, 2'd2, 10'(t));
      init_mem[2] = ins(4'h1, 2'd1, 10'd101);
      init_mem[3] = 16'h0000;
      init_mem[100] = ins(4'h3, 2'd3, 10'd102);
      init_mem[101] = 16'h00AA;
      init_mem[102] = 16'h0055;
      run_prog("self-modify R8");
      if (t == 2) check("R8 stored word executed", exp_reg[3], 16'h0055);
    end

    // R7: jumps forward, backward, to next word, and a taken branch
    clear_prog();
    init_mem[0] = ins(4'h4, 2'd0, 10'd3);
    init_mem[1] = ins(4'h1, 2'd0, 10'd100);
    init_mem[3] = ins(4'h1, 2'd1, 10'd101);
    init_mem[4] = ins(4'h4, 2'd0, 10'd5);
    init_mem[5] = ins(4'h5, 2'd2, 10'd1);
    init_mem[100] = 16'hBEEF;
    init_mem[101] = 16'hCAFE;
    run_prog("jumps R7");
    check("R7 jump bubbles", exp_bub, 3);

    // R11: load port ignored while running
    load_we = 1'b1;
    load_addr = AW'(100);
    load_data = 16'h1234;
    @(negedge clk);
    load_we = 1'b0;
    peek_addr = AW'(100);
    #1;
    check("R11 load port ignored after reset", peek_data, 16'hBEEF);
    check("R9 still halted", halted, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule